// File: doc/BRIEF.md
# Partitioned Array Access Policy

This block decides, at the start of every memory operation, whether the operation may go ahead. The memory it guards holds four arrays of 128 bytes, reached through a 9-bit byte address. Each array carries its own 4-bit policy, and the four policies are packed into two 8-bit control registers. Each policy says whether a password is needed for reads, whether one is needed for writes, and which kinds of access the array grants. A configuration override, raised when the caller holds the configuration credential, sets every policy aside.

Once an operation is granted, the block produces the byte address for each transfer. Write addresses step and wrap inside an 8-byte sector. Read addresses step and wrap inside the 128-byte array. In the program-only mode, each incoming write byte is compared with the byte already stored. Any attempt to turn a 0 bit into a 1 ends the operation. A denied start or a rejected byte raises a one-cycle return-to-standby pulse. The address then freezes until the next start.

Top module: `part_access_guard`

## Requirements
- R1: After a synchronous reset, `grant`, `pw_required` and `standby_pulse` are 0 and `byte_addr` is 0.
- R2: Address bits 8..7 select the array. The policy nibble of array i sits at bits 4i+3..4i of {`ctl_hi`,`ctl_lo`}. Within a nibble, bit 3 is the read-password bit, bit 2 is the write-password bit, bit 1 is function bit F1 and bit 0 is function bit F0.
- R3: A read is granted unless the array's function bits {F1,F0} are 11.
- R4: A write is granted only when {F1,F0} is 00 (free) or 01 (program-only). The value 10 means read only.
- R5: On the cycle after a start without override, `pw_required` equals the read-password bit for a read and the write-password bit for a write. The two bits act independently.
- R6: A start with `cfg_override` high is always granted and shows `pw_required` low, whatever the policy.
- R7: A denial drives `grant` low and pulses `standby_pulse` for exactly one cycle. After that, `byte_step` leaves `byte_addr` unchanged until the next start.
- R8: During a granted write, each `byte_step` increments `byte_addr` bits 2..0 modulo 8 and holds bits 8..3.
- R9: During a granted read, each `byte_step` increments `byte_addr` bits 6..0 modulo 128 and holds bits 8..7.
- R10: In a program-only write without override, a step whose `new_byte` has a 1 where `old_byte` has a 0 is a denial (as in R7) and does not advance the address. A step that only clears bits, or keeps them, advances normally.
- R11: On the cycle after any start, `byte_addr` equals the start address and the outcome reflects the new operation only. A start takes priority over a `byte_step` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_start | input | 1 | Begin a new operation this cycle |
| op_write | input | 1 | 1 = write operation, 0 = read operation |
| op_addr | input | 9 | Start byte address of the operation |
| cfg_override | input | 1 | Configuration access: bypass all array policies |
| byte_step | input | 1 | One byte transferred; advance the address |
| new_byte | input | 8 | Byte being written at the current address |
| old_byte | input | 8 | Byte currently stored at the current address |
| ctl_lo | input | 8 | Policies of arrays 1 (upper nibble) and 0 (lower nibble) |
| ctl_hi | input | 8 | Policies of arrays 3 (upper nibble) and 2 (lower nibble) |
| grant | output | 1 | Current operation is allowed |
| pw_required | output | 1 | Current operation needs its password |
| standby_pulse | output | 1 | One-cycle pulse on any denial |
| byte_addr | output | 9 | Byte address of the current transfer |

## Verification
A new start and a byte step can fall in the same cycle. So can a program-only violation and a step. The bench raises `op_start` together with `byte_step` in the middle of a write sector and expects the new start address with no extra advance. It also feeds a step carrying a 0-to-1 change and expects the pulse with the address frozen. A behavioural reference model predicts all four outputs for every clock, so any collision in the mixed traffic is judged as well.

// File: rtl/part_access_pkg.sv
package part_access_pkg;

  typedef enum logic [1:0] {
    FN_FREE   = 2'b00,
    FN_PROG   = 2'b01,
    FN_RDONLY = 2'b10,
    FN_LOCKED = 2'b11
  } func_t;

  typedef struct packed {
    logic rd_pw;
    logic wr_pw;
    logic rd_ok;
    logic wr_ok;
    logic prog_only;
  } arr_rule_t;

  function automatic arr_rule_t rule_of(input logic [3:0] nib);
    arr_rule_t r;
    func_t     f;
    f           = func_t'(nib[1:0]);
    r.rd_pw     = nib[3];
    r.wr_pw     = nib[2];
    r.rd_ok     = (f != FN_LOCKED);
    r.wr_ok     = (f == FN_FREE) || (f == FN_PROG);
    r.prog_only = (f == FN_PROG);
    return r;
  endfunction

endpackage

// File: rtl/part_access_decode.sv
module part_access_decode
  import part_access_pkg::*;
#(
  parameter int SEL_W   = 2,
  parameter int NIB_W   = 4,
  localparam int NUM_ARR = 1 << SEL_W,
  localparam int POL_W   = NUM_ARR * NIB_W
) (
  input  logic [POL_W-1:0] ctl_bits,
  input  logic [SEL_W-1:0] sel,
  output arr_rule_t        rule
);

  arr_rule_t rule_tbl [NUM_ARR];

  for (genvar i = 0; i < NUM_ARR; i++) begin : g_arr
    assign rule_tbl[i] = rule_of(ctl_bits[i*NIB_W +: 4]);
  end

  assign rule = rule_tbl[sel];

endmodule

// File: rtl/part_access_addr.sv
module part_access_addr #(
  parameter int ADDR_W = 9,
  parameter int BLK_W  = 7,
  parameter int SECT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              adv,
  input  logic              sector_mode,
  output logic [ADDR_W-1:0] addr_q
);

  logic [ADDR_W-1:0] sect_next;
  logic [ADDR_W-1:0] blk_next;
  logic [SECT_W-1:0] sect_low;
  logic [BLK_W-1:0]  blk_low;

  always_comb begin
    sect_low  = addr_q[SECT_W-1:0] + 1'b1;
    blk_low   = addr_q[BLK_W-1:0] + 1'b1;
    sect_next = {addr_q[ADDR_W-1:SECT_W], sect_low};
    blk_next  = {addr_q[ADDR_W-1:BLK_W], blk_low};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
    end else if (load) begin
      addr_q <= load_addr;
    end else if (adv) begin
      addr_q <= sector_mode ? sect_next : blk_next;
    end
  end

endmodule

// File: rtl/part_access_guard.sv
module part_access_guard
  import part_access_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int BLK_W  = 7,
  parameter int SECT_W = 3,
  parameter int DATA_W = 8,
  parameter int CTL_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_start,
  input  logic              op_write,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic              cfg_override,
  input  logic              byte_step,
  input  logic [DATA_W-1:0] new_byte,
  input  logic [DATA_W-1:0] old_byte,
  input  logic [CTL_W-1:0]  ctl_lo,
  input  logic [CTL_W-1:0]  ctl_hi,
  output logic              grant,
  output logic              pw_required,
  output logic              standby_pulse,
  output logic [ADDR_W-1:0] byte_addr
);

  localparam int SEL_W = ADDR_W - BLK_W;

  arr_rule_t rule;
  logic      start_ok;
  logic      start_pw;
  logic      sess_q;
  logic      wr_q;
  logic      prog_q;
  logic      violation;
  logic      adv;

  part_access_decode #(.SEL_W(SEL_W), .NIB_W(4)) u_decode (
    .ctl_bits (({ctl_hi, ctl_lo})),
    .sel      (op_addr[ADDR_W-1:BLK_W]),
    .rule     (rule)
  );

  always_comb begin
    if (cfg_override) begin
      start_ok = 1'b1;
      start_pw = 1'b0;
    end else if (op_write) begin
      start_ok = rule.wr_ok;
      start_pw = rule.wr_pw;
    end else begin
      start_ok = rule.rd_ok;
      start_pw = rule.rd_pw;
    end
  end

  assign violation = sess_q && wr_q && prog_q && (|(new_byte & ~old_byte));
  assign adv       = byte_step && sess_q && !violation && !op_start;

  always_ff @(posedge clk) begin
    if (rst) begin
      grant         <= 1'b0;
      pw_required   <= 1'b0;
      standby_pulse <= 1'b0;
      sess_q        <= 1'b0;
      wr_q          <= 1'b0;
      prog_q        <= 1'b0;
    end else begin
      standby_pulse <= 1'b0;
      if (op_start) begin
        grant         <= start_ok;
        pw_required   <= start_pw;
        sess_q        <= start_ok;
        standby_pulse <= !start_ok;
        wr_q          <= op_write;
        prog_q        <= op_write && !cfg_override && rule.prog_only;
      end else if (byte_step && violation) begin
        grant         <= 1'b0;
        sess_q        <= 1'b0;
        standby_pulse <= 1'b1;
      end
    end
  end

  part_access_addr #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .SECT_W(SECT_W)) u_addr (
    .clk         (clk),
    .rst         (rst),
    .load        (op_start),
    .load_addr   (op_addr),
    .adv         (adv),
    .sector_mode (wr_q),
    .addr_q      (byte_addr)
  );

endmodule

// File: rtl/part_access_guard_chk.sv
module part_access_guard_chk #(
  parameter int ADDR_W = 9,
  parameter int BLK_W  = 7,
  parameter int SECT_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              op_start,
  input logic [ADDR_W-1:0] op_addr,
  input logic              cfg_override,
  input logic              grant,
  input logic              pw_required,
  input logic              standby_pulse,
  input logic [ADDR_W-1:0] byte_addr,
  input logic              sess_q,
  input logic              wr_q
);

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    standby_pulse && !op_start |=> !standby_pulse); // R7

  AST_PULSE_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
    standby_pulse |-> !grant); // R7

  AST_FROZEN_AFTER_DENY: assert property (@(posedge clk) disable iff (rst)
    !sess_q && !op_start |=> $stable(byte_addr)); // R7

  AST_SECTOR_KEEP: assert property (@(posedge clk) disable iff (rst)
    sess_q && wr_q && !op_start |=> $stable(byte_addr[ADDR_W-1:SECT_W])); // R8

  AST_BLOCK_KEEP: assert property (@(posedge clk) disable iff (rst)
    sess_q && !wr_q && !op_start |=> $stable(byte_addr[ADDR_W-1:BLK_W])); // R9

  AST_OVERRIDE_GRANT: assert property (@(posedge clk) disable iff (rst)
    op_start && cfg_override |=> grant && !pw_required); // R6

  AST_START_LOADS: assert property (@(posedge clk) disable iff (rst)
    op_start |=> byte_addr == $past(op_addr)); // R11

endmodule

bind part_access_guard part_access_guard_chk #(
  .ADDR_W(ADDR_W), .BLK_W(BLK_W), .SECT_W(SECT_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .op_start      (op_start),
  .op_addr       (op_addr),
  .cfg_override  (cfg_override),
  .grant         (grant),
  .pw_required   (pw_required),
  .standby_pulse (standby_pulse),
  .byte_addr     (byte_addr),
  .sess_q        (sess_q),
  .wr_q          (wr_q)
);

// File: tb/part_access_guard_test.sv
module part_access_guard_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_start = 1'b0;
  logic       op_write = 1'b0;
  logic [8:0] op_addr = '0;
  logic       cfg_override = 1'b0;
  logic       byte_step = 1'b0;
  logic [7:0] new_byte = '0;
  logic [7:0] old_byte = '0;
  logic [7:0] ctl_lo = 8'hAC;
  logic [7:0] ctl_hi = 8'h35;
  logic       grant;
  logic       pw_required;
  logic       standby_pulse;
  logic [8:0] byte_addr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // reference model state
  int  m_grant = 0, m_pw = 0, m_pulse = 0, m_addr = 0;
  int  m_sess = 0, m_wr = 0, m_prog = 0;
  bit  model_on = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  part_access_guard uut (
    .clk(clk), .rst(rst), .op_start(op_start), .op_write(op_write),
    .op_addr(op_addr), .cfg_override(cfg_override), .byte_step(byte_step),
    .new_byte(new_byte), .old_byte(old_byte), .ctl_lo(ctl_lo), .ctl_hi(ctl_hi),
    .grant(grant), .pw_required(pw_required), .standby_pulse(standby_pulse),
    .byte_addr(byte_addr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_grant = 0; m_pw = 0; m_pulse = 0; m_addr = 0;
      m_sess = 0; m_wr = 0; m_prog = 0;
      model_on = 1;
    end else begin
      m_pulse = 0;
      if (op_start) begin
        int nib, fn;
        nib = (({ctl_hi, ctl_lo}) >> (4 * (op_addr / 128))) & 15;
        fn  = nib % 4;
        if (cfg_override) begin
          m_grant = 1; m_pw = 0;
        end else if (op_write) begin
          m_grant = (fn == 0 || fn == 1); m_pw = (nib / 4) % 2;
        end else begin
          m_grant = (fn != 3); m_pw = nib / 8;
        end
        m_sess  = m_grant;
        m_pulse = !m_grant;
        m_addr  = op_addr;
        m_wr    = op_write;
        m_prog  = op_write && !cfg_override && fn == 1;
      end else if (byte_step && m_sess) begin
        if (m_wr && m_prog && ((new_byte & ~old_byte) != 0)) begin
          m_grant = 0; m_sess = 0; m_pulse = 1;
        end else if (m_wr) begin
          m_addr = (m_addr / 8) * 8 + (m_addr + 1) % 8;
        end else begin
          m_addr = (m_addr / 128) * 128 + (m_addr + 1) % 128;
        end
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (model_on) begin
      chk("model grant", grant, m_grant);
      chk("model pw_required", pw_required, m_pw);
      chk("model standby_pulse", standby_pulse, m_pulse);
      chk("model byte_addr", byte_addr, m_addr);
    end
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic start_op(input bit wr, input int addr, input bit ovr);
    op_start = 1; op_write = wr; op_addr = 9'(addr); cfg_override = ovr;
    @(negedge clk);
    op_start = 0; cfg_override = 0;
  endtask

  task automatic step(input int nb, input int ob);
    byte_step = 1; new_byte = 8'(nb); old_byte = 8'(ob);
    @(negedge clk);
    byte_step = 0;
  endtask

  initial begin
    // array0 1100 rw, both pw; array1 1010 read only; array2 0101 program; array3 0011 locked
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 grant", grant, 0);
    chk("R1 pw", pw_required, 0);
    chk("R1 pulse", standby_pulse, 0);
    chk("R1 addr", byte_addr, 0);

    start_op(0, 'h005, 0);
    chk("R3 read free array", grant, 1);
    chk("R5 read pw bit", pw_required, 1);

    start_op(1, 'h0FA, 0);
    chk("R4 write to read-only", grant, 0);
    chk("R2 array1 selected", standby_pulse, 1);
    step(0, 0);
    chk("R7 pulse single", standby_pulse, 0);
    chk("R7 addr frozen", byte_addr, 'h0FA);

    start_op(0, 'h0FA, 0);
    chk("R5 read pw array1", pw_required, 1);
    repeat (6) step(0, 0);
    chk("R9 block wrap", byte_addr, 'h080);

    start_op(1, 'h03D, 0);
    chk("R4 write free", grant, 1);
    repeat (4) step(8'h11, 8'h00);
    chk("R8 sector wrap", byte_addr, 'h039);

    // R11: start and step collide
    op_start = 1; op_write = 0; op_addr = 9'h100; byte_step = 1;
    @(negedge clk);
    op_start = 0; byte_step = 0;
    chk("R11 start wins", byte_addr, 'h100);
    chk("R3 read program array", grant, 1);
    chk("R5 no read pw array2", pw_required, 0);

    start_op(0, 'h1C0, 0);
    chk("R3 locked read", grant, 0);
    start_op(0, 'h1C0, 1);
    chk("R6 override read", grant, 1);
    chk("R6 override pw", pw_required, 0);
    start_op(1, 'h1C8, 1);
    chk("R6 override write", grant, 1);

    start_op(1, 'h120, 0);
    chk("R5 write pw array2", pw_required, 1);
    step('h0F, 'hFF);
    chk("R10 clear bits ok", byte_addr, 'h121);
    step('h10, 'h0F);
    chk("R10 violation pulse", standby_pulse, 1);
    chk("R10 violation grant", grant, 0);
    chk("R10 addr hold", byte_addr, 'h121);
    step('h00, 'h00);
    chk("R7 frozen after violation", byte_addr, 'h121);

    // mixed traffic judged by the model
    for (int k = 0; k < 300; k++) begin
      ctl_lo = 8'((k * 37) ^ 8'h5A);
      ctl_hi = 8'((k * 91) ^ 8'hC3);
      if (k % 9 == 0) start_op(k % 2, (k * 53) % 512, (k % 5) == 0);
      else step((k * 29) % 256, (k * 71) % 256);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule